// File: doc/BRIEF.md
# Normalization Shift Amount Unit

This unit takes a 32-bit operand and returns how far it has to be shifted left to normalize it. Two counting modes are available. The unsigned mode counts leading zero bits. The signed mode counts the sign bits that are redundant. A caller presents the operand, a mode bit and a valid strobe. One clock later the unit returns a 6-bit amount, together with its own valid strobe.

In signed mode a negative operand is first inverted bit by bit, and the count is then taken on that value. For a positive signed operand, the amount returned is the left shift that moves the most significant set bit to the position just below the sign bit. Two inputs have fixed answers. A zero operand gives 32 in unsigned mode. A zero or all-ones operand gives 31 in signed mode.

The count is built by a chain of binary-search steps that narrow the search by 16, 8, 4, 2 and 1 bit positions. The unit does not apply the shift itself.

Top module: `lead_amt_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first accepted operand, `vld_o` is 0 and `amt_o` is 0.
- R2: `vld_o` is 1 in exactly the cycle after a clock edge at which `vld_i` was 1, and 0 after an edge at which `vld_i` was 0.
- R3: With `mode_i` = 0 (unsigned), an operand of 0 gives an amount of 32.
- R4: With `mode_i` = 0, a nonzero operand gives its number of leading zero bits, 0 to 31. An operand with bit 31 set gives 0.
- R5: With `mode_i` = 1 (signed), an operand with bit 31 set is inverted bit by bit before the count is taken. For example, 0xFFFF0000 gives 15.
- R6: With `mode_i` = 1, an operand of 0x00000000 or 0xFFFFFFFF gives 31.
- R7: With `mode_i` = 1, any other operand gives the leading-zero count of the (possibly inverted) value minus one. So 0x00000001 gives 30, 0x40000000 gives 0 and 0x80000000 gives 0.
- R8: `amt_o` holds its value across every edge at which `vld_i` is 0, whatever `data_i` and `mode_i` do.
- R9: `amt_o` never exceeds 32, and an amount produced in signed mode never exceeds 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operand strobe |
| mode_i | input | 1 | 0 = leading-zero count, 1 = redundant-sign count |
| data_i | input | 32 | Operand |
| vld_o | output | 1 | Result strobe, one cycle after `vld_i` |
| amt_o | output | 6 | Shift amount |

## Verification
Each binary-search step takes its decision independently of the others. A wrong decision at step w shows up at the ports as an amount that is off by w, on the very next `vld_o`, and only for operands whose top set bit lies in the affected range. The bench therefore sweeps the top set bit across all 32 positions in both modes, with varied lower bits. A fault in the fold or fixed-result logic shows up in the signed corner cases (0, all ones, 0x80000000, 1) one cycle after they are presented. A fault in the register enable shows up as `amt_o` moving while `vld_i` is low.

// File: rtl/lead_pkg.sv
package lead_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } lead_mode_e;

  localparam int unsigned LEAD_DATA_W = 32;
endpackage

// File: rtl/lead_fold.sv
// Signed mode: fold negative operands onto their positive image
module lead_fold #(
  parameter int DATA_W = 32
) (
  input  lead_pkg::lead_mode_e mode_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [DATA_W-1:0]    fold_o
);
  logic inv;

  always_comb begin
    inv    = (mode_i == lead_pkg::MODE_SIGNED) && data_i[DATA_W-1];
    fold_o = inv ? ~data_i : data_i;
  end
endmodule

// File: rtl/lead_bisect_step.sv
module lead_bisect_step #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 6,
  parameter int SHIFT  = 16
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] val_o,
  output logic [AMT_W-1:0]  cnt_o
);
  logic hit;

  always_comb begin
    hit   = |(val_i >> SHIFT);
    val_o = hit ? (val_i >> SHIFT) : val_i;
    cnt_o = hit ? (cnt_i - AMT_W'(SHIFT)) : cnt_i;
  end
endmodule

// File: rtl/lead_bisect.sv
module lead_bisect #(
  parameter  int DATA_W = 32,
  localparam int LOG_W  = $clog2(DATA_W),
  localparam int AMT_W  = LOG_W + 1
) (
  input  lead_pkg::lead_mode_e mode_i,
  input  logic [DATA_W-1:0]    val_i,
  output logic [AMT_W-1:0]     amt_o
);
  logic [DATA_W-1:0] val_c [LOG_W+1];
  logic [AMT_W-1:0]  cnt_c [LOG_W+1];
  logic              is_zero;

  assign val_c[0] = val_i;
  assign cnt_c[0] = AMT_W'(DATA_W - 1);

  for (genvar k = 0; k < LOG_W; k++) begin : g_step
    lead_bisect_step #(
      .DATA_W(DATA_W),
      .AMT_W (AMT_W),
      .SHIFT (1 << (LOG_W - 1 - k))
    ) i_step (
      .val_i(val_c[k]),
      .cnt_i(cnt_c[k]),
      .val_o(val_c[k+1]),
      .cnt_o(cnt_c[k+1])
    );
  end

  // after all steps the remainder is zero only for a zero operand
  always_comb begin
    is_zero = (val_c[LOG_W] == '0);
    if (mode_i == lead_pkg::MODE_SIGNED)
      amt_o = is_zero ? AMT_W'(DATA_W - 1) : (cnt_c[LOG_W] - AMT_W'(1));
    else
      amt_o = is_zero ? AMT_W'(DATA_W) : cnt_c[LOG_W];
  end
endmodule

// File: rtl/lead_amt_unit.sv
module lead_amt_unit #(
  parameter  int DATA_W = lead_pkg::LEAD_DATA_W,
  localparam int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [AMT_W-1:0]  amt_o
);
  lead_pkg::lead_mode_e mode;
  logic [DATA_W-1:0]    folded;
  logic [AMT_W-1:0]     amt_d;

  assign mode = lead_pkg::lead_mode_e'(mode_i);

  lead_fold #(.DATA_W(DATA_W)) i_fold (
    .mode_i(mode),
    .data_i(data_i),
    .fold_o(folded)
  );

  lead_bisect #(.DATA_W(DATA_W)) i_bisect (
    .mode_i(mode),
    .val_i (folded),
    .amt_o (amt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      amt_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) amt_o <= amt_d;
    end
  end
endmodule

// File: rtl/lead_amt_chk.sv
module lead_amt_chk #(
  parameter  int DATA_W = 32,
  localparam int AMT_W  = $clog2(DATA_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic              mode_i,
  input logic [DATA_W-1:0] data_i,
  input logic              vld_o,
  input logic [AMT_W-1:0]  amt_o
);
  a_r2_vld_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r2_vld_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r3_uns_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !mode_i && data_i == '0) |=> amt_o == AMT_W'(DATA_W));
  a_r4_uns_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !mode_i && data_i[DATA_W-1]) |=> amt_o == '0);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(amt_o));
  a_r9_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> amt_o <= AMT_W'(DATA_W));
  a_r9_sgn_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && mode_i) |=> amt_o <= AMT_W'(DATA_W - 1));
endmodule

bind lead_amt_unit lead_amt_chk #(.DATA_W(DATA_W)) i_lead_amt_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .vld_i (vld_i),
  .mode_i(mode_i),
  .data_i(data_i),
  .vld_o (vld_o),
  .amt_o (amt_o)
);

// File: tb/test_lead_amt_unit.sv
module test_lead_amt_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        vld_o;
  logic [5:0]  amt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lead_amt_unit i_lead_amt_unit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_i),
    .mode_i(mode_i),
    .data_i(data_i),
    .vld_o (vld_o),
    .amt_o (amt_o)
  );

  function automatic int lz(input logic [31:0] v);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int ref_amt(input logic m, input logic [31:0] d);
    logic [31:0] v;
    if (!m) return (d == 0) ? 32 : lz(d);
    v = d[31] ? ~d : d;
    return (v == 0) ? 31 : lz(v) - 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one operand and check result one cycle later
  task automatic issue(input string req, input logic m, input logic [31:0] d);
    @(negedge clk_i);
    vld_i = 1'b1; mode_i = m; data_i = d;
    @(negedge clk_i);
    vld_i = 1'b0;
    check({req, " vld"}, int'(vld_o), 1);
    check(req, int'(amt_o), ref_amt(m, d));
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk_i);
    check("R1 vld in reset", int'(vld_o), 0);
    check("R1 amt in reset", int'(amt_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 vld after reset", int'(vld_o), 0);
    check("R1 amt after reset", int'(amt_o), 0);
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    vld_i = 1'b1; mode_i = 1'b0; data_i = 32'h0000_0100;
    #1 check("R2 no early vld", int'(vld_o), 0);
    @(negedge clk_i);
    vld_i = 1'b0;
    check("R2 vld one cycle later", int'(vld_o), 1);
    check("R4 amt 0x100", int'(amt_o), 23);
    @(negedge clk_i);
    check("R2 vld drops", int'(vld_o), 0);
  endtask

  task automatic t_unsigned;
    issue("R3 unsigned zero", 1'b0, 32'h0);
    check("R3 literal 32", int'(amt_o), 32);
    for (int p = 0; p < 32; p++) begin
      logic [31:0] d = (32'h1 << p) | (32'h5A3C_96E1 & ((32'h1 << p) - 1));
      issue("R4 unsigned sweep", 1'b0, d);
      check("R4 literal", int'(amt_o), 31 - p);
    end
    issue("R4 all ones unsigned", 1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_signed;
    issue("R6 signed zero", 1'b1, 32'h0);
    check("R6 literal zero", int'(amt_o), 31);
    issue("R6 signed all ones", 1'b1, 32'hFFFF_FFFF);
    check("R6 literal ones", int'(amt_o), 31);
    issue("R5 signed 0xFFFF0000", 1'b1, 32'hFFFF_0000);
    check("R5 literal", int'(amt_o), 15);
    issue("R7 signed one", 1'b1, 32'h1);
    check("R7 literal one", int'(amt_o), 30);
    issue("R7 signed 0x40000000", 1'b1, 32'h4000_0000);
    check("R7 literal 0x4", int'(amt_o), 0);
    issue("R7 signed 0x80000000", 1'b1, 32'h8000_0000);
    check("R7 literal 0x8", int'(amt_o), 0);
    for (int p = 0; p < 31; p++) begin
      logic [31:0] d = (32'h1 << p) | (32'h2C71_B4E9 & ((32'h1 << p) - 1));
      issue("R7 signed positive sweep", 1'b1, d);
      check("R7 literal sweep", int'(amt_o), 30 - p);
      issue("R5 signed negative sweep", 1'b1, ~d);
      check("R5 literal sweep", int'(amt_o), 30 - p);
    end
  endtask

  task automatic t_hold;
    issue("R8 setup", 1'b0, 32'h0001_0000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      mode_i = i[0]; data_i = 32'h1 << (i * 7);
      @(negedge clk_i);
      check("R8 amt holds", int'(amt_o), 15);
      check("R2 vld idle", int'(vld_o), 0);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_unsigned();
    t_signed();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule